// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block is the host-side engine that copies a run of words into a parallel NOR-style flash device. Software or a DMA front end gives it a start pulse, a base address and a word count. The words themselves arrive on a valid/ready stream. For each word the block writes the device's four-cycle program command on a simple strobed bus. It then reads the target address over and over until the device's status bits show that the word is finished, that it failed, or that it took too long. After that it moves on to the next address.

The run ends in one of two ways: a one-cycle `done` pulse, or a sticky `err` flag together with the address that failed. Before the error is raised, the block writes the device's reset command so that the array can be read again. The stream side applies back-pressure: `src_ready` is high only while the engine is waiting for its next word. The source may hold `src_valid` low for as long as it likes. The engine then makes no bus cycles, and a word moves only on a cycle where `src_valid` and `src_ready` are both high.

Top module: `fsq_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bus_we`, `bus_re` and `src_ready` are all low.
- R2: For each word, exactly four write strobes go out in this order: 0x0AA to address 0x555, 0x055 to address 0x2AA, 0x0A0 to address 0x555, then the word to its target address.
- R3: `src_ready` is high only while the block waits for a word. A word is accepted only when `src_valid` and `src_ready` are high together. While it is stalled on the stream, the block makes no bus strobes.
- R4: Polling reads the target address. Read data is taken from `bus_rdata` in the cycle after `bus_re`. The word counts as complete when bit 7 of the read data equals bit 7 of the written word.
- R5: If a poll is incomplete and bit 5 is set, the block reads once more. If bit 7 then matches, the word counts as complete and no error is raised.
- R6: On a failure, the block writes 0x0F0 to the failing address. In the next cycle it raises `err` with `err_addr` set to that address. It does not pulse `done` and programs no further words. `err` stays high until the next start is accepted.
- R7: If POLL_LIMIT poll reads all return incomplete with bit 5 clear, the word fails as in R6. Exactly POLL_LIMIT reads are made.
- R8: Words go to consecutive addresses starting at `base_addr`. After the last word completes, `done` is high for exactly one cycle and `busy` falls.
- R9: A `start` while `busy` is high is ignored. The running job's addresses and word count do not change.
- R10: A start with `word_count` = 0 pulses `done` in the next cycle and makes no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (ignored while busy) |
| base_addr | input | AW | First target address |
| word_count | input | CW | Number of words to program |
| src_valid | input | 1 | Stream word available |
| src_ready | output | 1 | Engine can take a word |
| src_data | input | DW | Stream word |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | DW | Flash bus write data |
| bus_we | output | 1 | Single-cycle write strobe |
| bus_re | output | 1 | Single-cycle read strobe |
| bus_rdata | input | DW | Read data, valid the cycle after `bus_re` |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job completes |
| err | output | 1 | Sticky failure flag |
| err_addr | output | AW | Address whose programming failed |

## Verification
Several properties are checked on every cycle by assertions:
- A stalled stream makes no bus traffic.
- A bit-5 fault is always followed by a re-read.
- An expired poll budget always leads to a reset write.
- `err` never rises unless the reset command was written in the cycle before.
- `done` is a single clean pulse.

Other behaviour can only be shown by the bench's scenarios, which run against a device model that checks the bus protocol:
- the exact unlock order;
- the words landing at consecutive addresses with the right data;
- the bit-5 race that resolves on the re-read;
- a hard failure in the middle of a job;
- the exact number of reads before a timeout;
- a start ignored while busy;
- a zero-length job.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_UNL1, S_UNL2, S_SETUP, S_PROG,
    S_POLL_RD, S_POLL_CHK, S_RECHK_RD, S_RECHK_CHK, S_ABORT, S_NEXT
  } fsq_state_e;

  localparam int unsigned UNLOCK_ADDR1 = 32'h555;
  localparam int unsigned UNLOCK_ADDR2 = 32'h2AA;
  localparam logic [7:0]  CMD_UNLOCK1  = 8'hAA;
  localparam logic [7:0]  CMD_UNLOCK2  = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0]  CMD_RESET    = 8'hF0;
  localparam int unsigned BIT_DONE     = 7;
  localparam int unsigned BIT_FAULT    = 5;
endpackage

// File: rtl/fsq_cmd_gen.sv
module fsq_cmd_gen
  import fsq_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  fsq_state_e      state_i,
  input  logic [AW-1:0]   tgt_addr_i,
  input  logic [DW-1:0]   tgt_data_i,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic            we_o,
  output logic            re_o
);
  always_comb begin
    addr_o = tgt_addr_i;
    data_o = '0;
    we_o   = 1'b0;
    re_o   = 1'b0;
    unique case (state_i)
      S_UNL1: begin
        addr_o = AW'(UNLOCK_ADDR1); data_o = DW'(CMD_UNLOCK1); we_o = 1'b1;
      end
      S_UNL2: begin
        addr_o = AW'(UNLOCK_ADDR2); data_o = DW'(CMD_UNLOCK2); we_o = 1'b1;
      end
      S_SETUP: begin
        addr_o = AW'(UNLOCK_ADDR1); data_o = DW'(CMD_PROGRAM); we_o = 1'b1;
      end
      S_PROG:     begin data_o = tgt_data_i;       we_o = 1'b1; end
      S_ABORT:    begin data_o = DW'(CMD_RESET);   we_o = 1'b1; end
      S_POLL_RD,
      S_RECHK_RD: re_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fsq_status_eval.sv
module fsq_status_eval
  import fsq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] want_i,
  output logic          complete_o,
  output logic          fault_o
);
  logic unused_bits;
  assign unused_bits = ^{rdata_i, want_i};
  assign complete_o  = rdata_i[BIT_DONE] == want_i[BIT_DONE];
  assign fault_o     = rdata_i[BIT_FAULT];
endmodule

// File: rtl/fsq_poll_timer.sv
module fsq_poll_timer #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = cnt_q == TOP;

  // R7: a freshly cleared budget is never already spent
  p_clear_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !expired_o);
endmodule

// File: rtl/fsq_prog_seq.sv
module fsq_prog_seq
  import fsq_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned DW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned POLL_LIMIT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_count,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] err_addr
);
  localparam logic [CW-1:0] ONE_LEFT = CW'(1);

  fsq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, err_addr_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] data_q;
  logic          done_q, err_q;
  logic          complete, fault, expired;

  fsq_cmd_gen #(.AW(AW), .DW(DW)) u_cmd (
    .state_i(state_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .addr_o(bus_addr), .data_o(bus_wdata), .we_o(bus_we), .re_o(bus_re)
  );

  fsq_status_eval #(.DW(DW)) u_eval (
    .rdata_i(bus_rdata), .want_i(data_q),
    .complete_o(complete), .fault_o(fault)
  );

  fsq_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state_q == S_PROG), .tick_i(state_q == S_POLL_RD),
    .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start && word_count != '0) state_d = S_FETCH;
      S_FETCH:     if (src_valid) state_d = S_UNL1;
      S_UNL1:      state_d = S_UNL2;
      S_UNL2:      state_d = S_SETUP;
      S_SETUP:     state_d = S_PROG;
      S_PROG:      state_d = S_POLL_RD;
      S_POLL_RD:   state_d = S_POLL_CHK;
      S_POLL_CHK: begin
        if (complete)     state_d = S_NEXT;
        else if (fault)   state_d = S_RECHK_RD;
        else if (expired) state_d = S_ABORT;
        else              state_d = S_POLL_RD;
      end
      S_RECHK_RD:  state_d = S_RECHK_CHK;
      S_RECHK_CHK: state_d = complete ? S_NEXT : S_ABORT;
      S_ABORT:     state_d = S_IDLE;
      S_NEXT:      state_d = (left_q == ONE_LEFT) ? S_IDLE : S_FETCH;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      left_q     <= '0;
      data_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          addr_q <= base_addr;
          left_q <= word_count;
          err_q  <= 1'b0;
          if (word_count == '0) done_q <= 1'b1;
        end
        S_FETCH: if (src_valid) data_q <= src_data;
        S_ABORT: begin
          err_q      <= 1'b1;
          err_addr_q <= addr_q;
        end
        S_NEXT: begin
          if (left_q == ONE_LEFT) done_q <= 1'b1;
          else begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign src_ready = state_q == S_FETCH;
  assign busy      = state_q != S_IDLE;
  assign done      = done_q;
  assign err       = err_q;
  assign err_addr  = err_addr_q;

  // R3: waiting on an empty stream produces no bus cycles
  p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !src_valid) |=> (!bus_we && !bus_re));

  // R5: an incomplete poll with the fault bit is followed by one more read
  p_reread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POLL_CHK && !complete && fault) |=> bus_re);

  // R6: the error flag only rises right after the reset command went out
  p_reset_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(bus_we) && $past(bus_wdata) == DW'(CMD_RESET)));

  // R7: a spent poll budget leads straight to the reset write
  p_timeout_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POLL_CHK && !complete && !fault && expired)
      |=> (bus_we && bus_wdata == DW'(CMD_RESET)));

  // R8: done is a single clean pulse
  p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a start during a job leaves the reported failure address alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q != S_ABORT) |=> $stable(err_addr));
endmodule

// File: tb/sim_fsq_prog_seq.sv
`timescale 1ns/1ps
module sim_fsq_prog_seq;
  localparam int AW = 20, DW = 16, CW = 16, LIM = 40;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic src_valid, src_ready;
  logic [DW-1:0] src_data;
  logic [AW-1:0] bus_addr, err_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_we, bus_re, busy, done, err;

  always #2.5 clk = ~clk;

  fsq_prog_seq #(.AW(AW), .DW(DW), .CW(CW), .POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .busy(busy),
    .done(done), .err(err), .err_addr(err_addr));

  int checks = 0, errors = 0;

  function automatic logic [15:0] pat(input int i);
    return 16'(32'h3C5A ^ (i * 32'h2B91));
  endfunction

  // stream source
  int feed_idx = 0, feed_lim = 0, cyc = 0;
  bit gap_mode = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy) feed_idx <= 0;
    else if (src_valid && src_ready) feed_idx <= feed_idx + 1;
  end
  assign src_valid = (feed_idx < feed_lim) && (!gap_mode || (cyc % 3 == 2));
  assign src_data  = pat(feed_idx);

  // flash device model
  logic [15:0] mem [64];
  int wr_cnt = 0, rd_cnt = 0, reset_cnt = 0, viol = 0, prog_n = 0;
  int prog_addr [64];
  logic [15:0] prog_data [64];
  int m_step = 0, m_left = 0, prog_delay = 6;
  bit m_stuck = 0, m_stuck_fail = 0, race_mode = 0, hang_mode = 0;
  logic [AW-1:0] m_tgt = '0, fail_at = '1;
  logic [15:0] m_tdat = '0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;

  always @(posedge clk) begin
    logic [15:0] r;
    bit mbusy;
    mbusy = m_stuck || (m_left > 0);
    if (bus_re) begin
      rd_cnt++;
      if (mbusy) begin
        if (bus_addr != m_tgt) viol++;
        r = '0;
        r[7] = ~m_tdat[7];
        if (m_stuck_fail) r[5] = 1'b1;
        if (race_mode && !m_stuck && m_left <= 2) begin r[5] = 1'b1; m_left = 0; end
        bus_rdata <= r;
      end else bus_rdata <= mem[bus_addr[5:0]];
    end
    if (bus_we) begin
      wr_cnt++;
      if (bus_wdata == 16'h00F0) begin
        reset_cnt++; m_step = 0; m_stuck = 0; m_stuck_fail = 0; m_left = 0;
      end else if (mbusy) viol++;
      else begin
        case (m_step)
          0: if (bus_addr == 20'h555 && bus_wdata == 16'h00AA) m_step = 1; else viol++;
          1: if (bus_addr == 20'h2AA && bus_wdata == 16'h0055) m_step = 2;
             else begin viol++; m_step = 0; end
          2: if (bus_addr == 20'h555 && bus_wdata == 16'h00A0) m_step = 3;
             else begin viol++; m_step = 0; end
          default: begin
            prog_addr[prog_n] = int'(bus_addr);
            prog_data[prog_n] = bus_wdata;
            prog_n++;
            mem[bus_addr[5:0]] = mem[bus_addr[5:0]] & bus_wdata;
            m_tgt = bus_addr; m_tdat = bus_wdata; m_left = prog_delay;
            if (bus_addr == fail_at) begin m_stuck = 1; m_stuck_fail = 1; end
            if (hang_mode) m_stuck = 1;
            m_step = 0;
          end
        endcase
      end
    end
    if (!m_stuck && m_left > 0) m_left--;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic kick(input int base, input int n);
    @(negedge clk);
    base_addr = AW'(base); word_count = CW'(n); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    int t = 0;
    got_done = 0; got_err = 0;
    while (!done && !err && t < 5000) begin @(negedge clk); t++; end
    got_done = done; got_err = err;
    if (t >= 5000) chk("R8", "job timed out", 0, 1);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset outputs busy/done/err/we/re/ready",
        {busy, done, err, bus_we, bus_re, src_ready}, 0);
  endtask

  task automatic t_basic;
    int p0 = prog_n, v0 = viol; bit d, e;
    feed_lim = 4; gap_mode = 0;
    kick(0, 4); wait_end(d, e);
    chk("R8", "done pulse", d, 1);
    chk("R8", "no error", e, 0);
    chk("R2", "words programmed", prog_n - p0, 4);
    chk("R2", "protocol violations", viol - v0, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R8", "consecutive address", prog_addr[p0 + i], i);
      chk("R4", "array word after completion", mem[i], pat(i));
    end
    @(negedge clk);
    chk("R8", "done one cycle, busy low", {done, busy}, 0);
  endtask

  task automatic t_backpressure;
    int p0 = prog_n, w0 = wr_cnt, v0 = viol; bit d, e;
    feed_lim = 3; gap_mode = 1;
    repeat (4) @(negedge clk);
    chk("R3", "ready low while idle with valid offered", src_ready, 0);
    kick(8, 3); wait_end(d, e);
    chk("R3", "done with stalls", d, 1);
    chk("R3", "writes equal four per word", wr_cnt - w0, 12);
    chk("R3", "protocol violations", viol - v0, 0);
    for (int i = 0; i < 3; i++) chk("R3", "stream order data", prog_data[p0 + i], pat(i));
    gap_mode = 0;
  endtask

  task automatic t_race;
    int r0 = reset_cnt; bit d, e;
    feed_lim = 2; race_mode = 1;
    kick(16, 2); wait_end(d, e);
    chk("R5", "fault bit resolved by reread gives done", d, 1);
    chk("R5", "no error", e, 0);
    chk("R5", "no reset command", reset_cnt - r0, 0);
    race_mode = 0;
  endtask

  task automatic t_fail;
    int p0 = prog_n, r0 = reset_cnt; bit d, e;
    feed_lim = 4; fail_at = 20'h19;
    kick(24, 4); wait_end(d, e);
    chk("R6", "error raised", e, 1);
    chk("R6", "no done", d, 0);
    chk("R6", "failing address", err_addr, 20'h19);
    chk("R6", "reset command written once", reset_cnt - r0, 1);
    chk("R6", "later words not programmed", prog_n - p0, 2);
    repeat (5) @(negedge clk);
    chk("R6", "error stays high", err, 1);
    fail_at = '1;
  endtask

  task automatic t_zero;
    int w0 = wr_cnt, q0 = rd_cnt;
    kick(40, 0);
    chk("R10", "done next cycle", done, 1);
    chk("R6", "start clears error", err, 0);
    chk("R10", "no bus cycles", (wr_cnt - w0) + (rd_cnt - q0), 0);
  endtask

  task automatic t_timeout;
    int q0, r0 = reset_cnt, p0 = prog_n; bit d, e;
    feed_lim = 2; hang_mode = 1;
    kick(32, 2);
    while (prog_n == p0) @(negedge clk);
    q0 = rd_cnt;
    wait_end(d, e);
    chk("R7", "timeout error", e, 1);
    chk("R7", "failing address", err_addr, 32);
    chk("R7", "poll reads before giving up", rd_cnt - q0, LIM);
    chk("R7", "reset command written", reset_cnt - r0, 1);
    hang_mode = 0;
  endtask

  task automatic t_restart_ignored;
    int p0 = prog_n; bit d, e;
    feed_lim = 3;
    kick(40, 3);
    repeat (8) @(negedge clk);
    base_addr = 20'h30; word_count = 5; start = 1;
    @(negedge clk); start = 0;
    wait_end(d, e);
    chk("R9", "done for first job", d, 1);
    chk("R9", "word count unchanged", prog_n - p0, 3);
    for (int i = 0; i < 3; i++) chk("R9", "address from first job", prog_addr[p0 + i], 40 + i);
    chk("R6", "error cleared by new start", err, 0);
    repeat (3) @(negedge clk);
    chk("R9", "idle after job", busy, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_race();
    t_fail();
    t_zero();
    t_timeout();
    t_restart_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule